// File: doc/BRIEF.md
# Bit-Reversed Address Sequencer

This block issues the address stream needed to move radix-2 FFT data between scrambled (bit-reversed) order and natural order. Software-side configuration selects the transform size as a power of two, an ordering mode, a base address and, for one of the modes, a step. A start pulse loads that configuration and rewinds the sequence. Each advance pulse then issues one address, which appears on the output one cycle later together with a valid strobe.

Two ordering modes are available. In mirror mode, an internal index counts 0, 1, 2, ... and the low log2(N) bits of that index are reversed before the base is added. In reverse-carry mode, an internal pointer starts at zero and is stepped by an adder whose carries ripple from the top bit of the active field toward bit 0. With a step of N/2 this produces the same order as mirror mode. Other steps produce other strided orders. After N addresses have been issued, a done flag goes high. The next advance begins the sequence again from the first address.

Top module: `bitrev_addr_seq`

## Requirements
- R1: After reset, `addr_valid` and `seq_done` are 0 and `addr_out` is 0.
- R2: A `start` pulse does the following in one step. It latches `cfg_log2n`, `cfg_mode`, `cfg_base` and `cfg_step`. It forces `cfg_log2n` into the range 1..10, so 0 acts as 1 and values above 10 act as 10. It rewinds the sequence and clears `seq_done`. No address is issued for that cycle, so `addr_valid` is 0 in the following cycle even if `advance` was also high.
- R3: An `advance` cycle without `start` makes `addr_valid` high in the next cycle with the new address. A cycle with neither `start` nor `advance` makes `addr_valid` low in the next cycle.
- R4: In mirror mode (`cfg_mode`=0), the k-th address after start (k counted from 0) is base plus k with its low L=log2(N) bits reversed. For N=8 the offsets are 0,4,2,6,1,5,3,7.
- R5: In reverse-carry mode (`cfg_mode`=1), the first offset is 0. Each later offset is the previous offset plus `cfg_step`, with the addition confined to bits L-1..0. In that addition, carries move from bit L-1 toward bit 0, the carry out of bit 0 is dropped, and step bits at or above L are ignored.
- R6: In reverse-carry mode with `cfg_step` = N/2, the sequence equals the mirror-mode sequence for every size from 2 to 1024.
- R7: `seq_done` goes high in the same cycle as the N-th valid address. It stays high through idle cycles. The next `advance` issues offset 0 again and drops `seq_done`.
- R8: `addr_out` = `cfg_base` + offset, taken modulo 2^ADDR_W.
- R9: In mirror mode, and in reverse-carry mode with step N/2, the N offsets of one pass are all distinct and cover 0..N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load configuration and rewind the sequence |
| advance | input | 1 | Issue the next address |
| cfg_log2n | input | 4 | log2 of the transform size (clamped to 1..10) |
| cfg_mode | input | 1 | 0 = mirror, 1 = reverse-carry |
| cfg_base | input | ADDR_W | Base address added to every offset |
| cfg_step | input | 10 | Step for reverse-carry mode |
| addr_out | output | ADDR_W | Issued address |
| addr_valid | output | 1 | `addr_out` holds a newly issued address |
| seq_done | output | 1 | The N-th address of the pass has been issued |

## Verification
Two events can fall in the same cycle: a rewind and an issue. The first case is `start` and `advance` raised together partway through a pass. The bench expects no valid address in the next cycle, followed by offset 0 on the next advance. The second case is an `advance` arriving while `seq_done` is high. The bench expects the pass to wrap to offset 0 and the flag to drop in that same output cycle. Both modes are also run across every size against reference models built in the bench, with random bases, random steps and random idle gaps.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

    localparam int BR_MAX_LOG = 10;
    localparam int BR_LOGW    = $clog2(BR_MAX_LOG + 1);

    typedef logic [BR_MAX_LOG-1:0] idx_t;
    typedef logic [BR_LOGW-1:0]    lg_t;

    typedef enum logic {
        MODE_MIRROR = 1'b0,
        MODE_RCARRY = 1'b1
    } order_mode_e;

    typedef struct packed {
        lg_t         lg;
        order_mode_e mode;
        idx_t        step;
    } seq_cfg_t;

    // Force a requested field width into 1..BR_MAX_LOG
    function automatic lg_t clamp_lg(input lg_t v);
        if (v == '0)
            return lg_t'(1);
        if (v > lg_t'(BR_MAX_LOG))
            return lg_t'(BR_MAX_LOG);
        return v;
    endfunction

    // Highest index of a pass of 2**n points
    function automatic idx_t last_index(input lg_t n);
        return idx_t'({BR_MAX_LOG{1'b1}} >> (lg_t'(BR_MAX_LOG) - n));
    endfunction

    // Reverse the low n bits of v; bits at or above n become zero
    function automatic idx_t mirror_bits(input idx_t v, input lg_t n);
        idx_t r;
        lg_t  sel;
        r = '0;
        for (int i = 0; i < BR_MAX_LOG; i++) begin
            if (i < int'(n)) begin
                sel  = n - lg_t'(1) - lg_t'(i);
                r[i] = v[sel];
            end
        end
        return r;
    endfunction

    // Add within the low n bits, carries travelling from bit n-1 toward bit 0
    function automatic idx_t rc_add(input idx_t a, input idx_t b, input lg_t n);
        idx_t s;
        logic c;
        s = '0;
        c = 1'b0;
        for (int i = BR_MAX_LOG - 1; i >= 0; i--) begin
            if (i < int'(n)) begin
                s[i] = a[i] ^ b[i] ^ c;
                c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/brseq_cfg.sv
module brseq_cfg
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  lg_t               in_lg,
    input  logic              in_mode,
    input  logic [ADDR_W-1:0] in_base,
    input  idx_t              in_step,
    output seq_cfg_t          cfg,
    output logic [ADDR_W-1:0] base
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '{lg: lg_t'(1), mode: MODE_MIRROR, step: '0};
            base <= '0;
        end else if (start) begin
            cfg.lg   <= clamp_lg(in_lg);
            cfg.mode <= order_mode_e'(in_mode);
            cfg.step <= in_step;
            base     <= in_base;
        end
    end

    // R2: a latched width is always inside the supported range
    p_lg_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg.lg != '0) && (cfg.lg <= lg_t'(BR_MAX_LOG)));

endmodule

// File: rtl/brseq_index.sv
module brseq_index
    import brseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     issue,
    input  seq_cfg_t cfg,
    output idx_t     offset,
    output logic     done
);

    idx_t cnt_q;
    idx_t ptr_q;
    logic done_q;
    logic last;

    assign last   = (cnt_q == last_index(cfg.lg));
    assign offset = (cfg.mode == MODE_RCARRY) ? ptr_q : mirror_bits(cnt_q, cfg.lg);
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q  <= '0;
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else if (issue) begin
            done_q <= last;
            if (last) begin
                cnt_q <= '0;
                ptr_q <= '0;
            end else begin
                cnt_q <= cnt_q + idx_t'(1);
                ptr_q <= rc_add(ptr_q, cfg.step, cfg.lg);
            end
        end
    end

    // R7: the issue counter never passes the last index of the pass
    p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_index(cfg.lg));

    // R7: issuing the final index raises done on the next edge
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (issue && !start && last) |=> done_q);

    // R7: done stays put while nothing is issued or started
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!issue && !start) |=> $stable(done_q));

endmodule

// File: rtl/brseq_emit.sv
module brseq_emit
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [ADDR_W-1:0] base,
    input  idx_t              offset,
    output logic [ADDR_W-1:0] addr,
    output logic              vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            addr <= '0;
        end else begin
            vld <= issue;
            if (issue)
                addr <= base + ADDR_W'(offset);
        end
    end

    // R3: an issue produces a valid strobe one cycle later
    p_valid_follows_issue_r3: assert property (@(posedge clk) disable iff (rst)
        issue |=> vld);

    // R3: no issue, no strobe
    p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !vld);

    // R8: the address holds between issues
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(addr));

endmodule

// File: rtl/bitrev_addr_seq.sv
module bitrev_addr_seq
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  advance,
    input  logic [BR_LOGW-1:0]    cfg_log2n,
    input  logic                  cfg_mode,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [BR_MAX_LOG-1:0] cfg_step,
    output logic [ADDR_W-1:0]     addr_out,
    output logic                  addr_valid,
    output logic                  seq_done
);

    seq_cfg_t          cfg;
    logic [ADDR_W-1:0] base;
    idx_t              offset;
    logic              issue;
    logic [ADDR_W-1:0] rel;

    // A rewind takes priority over an issue in the same cycle
    assign issue = advance & ~start;

    brseq_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .in_lg   (cfg_log2n),
        .in_mode (cfg_mode),
        .in_base (cfg_base),
        .in_step (cfg_step),
        .cfg     (cfg),
        .base    (base)
    );

    brseq_index u_index (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .issue  (issue),
        .cfg    (cfg),
        .offset (offset),
        .done   (seq_done)
    );

    brseq_emit #(.ADDR_W(ADDR_W)) u_emit (
        .clk    (clk),
        .rst    (rst),
        .issue  (issue),
        .base   (base),
        .offset (offset),
        .addr   (addr_out),
        .vld    (addr_valid)
    );

    assign rel = addr_out - base;

    // R2: a start cycle never yields an address and always clears done
    p_start_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (!addr_valid && !seq_done));

    // R7: done can only rise together with a freshly issued address
    p_done_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> addr_valid);

    // R8: every issued address lies inside the window above the base
    p_addr_window_r8: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (rel <= ADDR_W'(last_index(cfg.lg))));

endmodule

// File: tb/bitrev_addr_seq_tb.sv
module bitrev_addr_seq_tb;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              advance = 1'b0;
    logic [3:0]        cfg_log2n = 4'd1;
    logic              cfg_mode = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [9:0]        cfg_step = '0;
    logic [ADDR_W-1:0] addr_out;
    logic              addr_valid;
    logic              seq_done;

    int n_checks = 0;
    int n_errors = 0;
    bit seen [0:1023];

    bitrev_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .advance    (advance),
        .cfg_log2n  (cfg_log2n),
        .cfg_mode   (cfg_mode),
        .cfg_base   (cfg_base),
        .cfg_step   (cfg_step),
        .addr_out   (addr_out),
        .addr_valid (addr_valid),
        .seq_done   (seq_done)
    );

    always #5 clk = ~clk;

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_lg(input int v);
        if (v == 0) return 1;
        if (v > 10) return 10;
        return v;
    endfunction

    function automatic int ref_rev(input int k, input int n);
        int r = 0;
        for (int i = 0; i < n; i++) r = (r << 1) | ((k >> i) & 1);
        return r;
    endfunction

    function automatic int ref_rc(input int a, input int b, input int n);
        int mask = (1 << n) - 1;
        int s = (ref_rev(a & mask, n) + ref_rev(b & mask, n)) & mask;
        return ref_rev(s, n);
    endfunction

    // Drive one cycle at the falling edge, settle after the rising edge
    task automatic cyc(input bit st, input bit adv);
        @(negedge clk);
        start   = st;
        advance = adv;
        @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input int mode, input int lg_in, input int base, input int step,
                           input bit gaps, input bit perm, input string req);
        int n, npts, off, exp_addr;
        cfg_mode  = mode[0];
        cfg_log2n = lg_in[3:0];
        cfg_base  = base[ADDR_W-1:0];
        cfg_step  = step[9:0];
        cyc(1'b1, 1'b0);
        chk("R2", "valid after start", int'(addr_valid), 0);
        chk("R2", "done after start", int'(seq_done), 0);
        n    = eff_lg(lg_in);
        npts = 1 << n;
        off  = 0;
        for (int i = 0; i < 1024; i++) seen[i] = 1'b0;
        for (int k = 0; k < npts; k++) begin
            if (gaps && $urandom_range(0, 2) == 0) begin
                cyc(1'b0, 1'b0);
                chk("R3", "valid on idle", int'(addr_valid), 0);
            end
            cyc(1'b0, 1'b1);
            if (mode == 0) off = ref_rev(k, n);
            else if (k > 0) off = ref_rc(off, step, n);
            exp_addr = (base + off) & 32'hFFFF;
            chk(req, "address", int'(addr_out), exp_addr);
            chk("R3", "valid on advance", int'(addr_valid), 1);
            chk("R7", "done flag", int'(seq_done), (k == npts - 1) ? 1 : 0);
            if (perm) begin
                chk("R9", "repeat offset", int'(seen[off]), 0);
                seen[off] = 1'b1;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "valid in reset", int'(addr_valid), 0);
        chk("R1", "done in reset", int'(seq_done), 0);
        chk("R1", "addr in reset", int'(addr_out), 0);
        @(negedge clk);
        rst = 1'b0;

        // R4 / R6 / R9: every size, both modes
        for (int lg = 1; lg <= 10; lg++) begin
            int b = int'($urandom_range(0, 65535));
            run_seq(0, lg, b, 0, 1'b0, 1'b1, "R4");
            run_seq(1, lg, b, 1 << (lg - 1), 1'b0, 1'b1, "R6");
        end

        // R5: random steps, upper step bits set at random, with idle gaps
        for (int t = 0; t < 8; t++) begin
            run_seq(1, int'($urandom_range(2, 6)), int'($urandom_range(0, 65535)),
                    int'($urandom_range(0, 1023)), 1'b1, 1'b0, "R5");
        end

        // R3: mirror pass with random idle cycles
        run_seq(0, 5, int'($urandom_range(0, 65535)), 0, 1'b1, 1'b1, "R3");

        // R7: done holds while idle, next advance wraps
        run_seq(0, 3, 0, 0, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0);
            chk("R7", "done held idle", int'(seq_done), 1);
            chk("R3", "valid idle", int'(addr_valid), 0);
        end
        cyc(1'b0, 1'b1);
        chk("R7", "wrap address", int'(addr_out), 0);
        chk("R7", "done cleared on wrap", int'(seq_done), 0);
        cyc(1'b0, 1'b1);
        chk("R7", "second after wrap", int'(addr_out), 4);

        // R2: start and advance in the same cycle
        cfg_mode = 1'b0; cfg_log2n = 4'd3; cfg_base = 16'h0100; cfg_step = '0;
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        chk("R4", "first", int'(addr_out), 'h100);
        cyc(1'b0, 1'b1);
        chk("R4", "second", int'(addr_out), 'h104);
        cyc(1'b0, 1'b1);
        chk("R4", "third", int'(addr_out), 'h102);
        cyc(1'b1, 1'b1);
        chk("R2", "start beats advance valid", int'(addr_valid), 0);
        chk("R2", "start beats advance done", int'(seq_done), 0);
        cyc(1'b0, 1'b1);
        chk("R2", "rewound to index 0", int'(addr_out), 'h100);
        cyc(1'b0, 1'b1);
        chk("R2", "rewound second", int'(addr_out), 'h104);

        // R2: width clamping at both ends
        run_seq(0, 0, 16'h0040, 0, 1'b0, 1'b1, "R2");
        run_seq(1, 15, 16'h2000, 512, 1'b0, 1'b1, "R2");

        // R8: base near the top wraps modulo 2**ADDR_W
        run_seq(0, 3, 16'hFFFE, 0, 1'b0, 1'b1, "R8");

        cyc(1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule